// File: doc/BRIEF.md
# USB Host Root-Port Suspend/Resume Sequencer

This block controls the suspend and resume states of one USB root port on the host side. In normal running it issues a start-of-frame marker on every 1 ms tick. When software withdraws frame enable, the markers stop and the port is suspended. Three ticks later, when the attached device is taken to have gone to sleep itself, the block reports that suspend has settled. While suspended it watches the filtered bus line state. Any departure from idle raises a wakeup flag. A K state, which is the device signalling resume upstream, also raises a resume-received flag and starts a deadline for the host's reply.

Software replies in two steps. It first re-enables frame generation, which moves the port to a ready state with markers still held off. It then requests the downstream resume. The block drives K for a fixed minimum length, drives two low-speed bit times of SE0 as an end-of-packet, and waits for the next tick. On that tick it issues a marker and returns to running. All control inputs are single-cycle write strobes and all status is plain level outputs. There is no streaming data path, so no valid/ready handshake appears.

Top module: `usbh_susp_seq`

## Requirements
- R1: After reset the port is running: `sof_enabled`=1, `flag_q`=0, `drive_k`=0, `drive_se0`=0, `susp_settled`=0, and `sof_marker` equals `tick_1ms` in the same cycle.
- R2: A `sof_stop` strobe while running clears `sof_enabled` from the next cycle. From then on no `sof_marker` is produced while suspended.
- R3: `susp_settled` rises after the SETTLE_MS-th (default 3) tick counted from entry to suspend, and is low before that tick.
- R4: `line_state` is encoded SE0=00, J=01, K=10, SE1=11, with J as idle. A value held for one sample only is ignored. A non-J value held for at least two consecutive cycles while suspended sets the wakeup flag, `flag_q[0]`.
- R5: When that non-J value is K, the resume-received flag `flag_q[1]` is set as well. SE0 or SE1 set only `flag_q[0]`.
- R6: The flags are sticky. Writing 1 to `flag_clr[i]` clears `flag_q[i]`. If a set and a clear of the same flag fall in the same cycle, the flag stays set.
- R7: If no downstream resume has started by the DEADLINE_MS-th (default 2) tick after a resume was received, the timeout flag `flag_q[2]` is set.
- R8: A `sof_start` strobe while suspended enters the ready state: `sof_enabled`=1 and still no markers. A `resume_req` strobe made while suspended is ignored.
- R9: A `resume_req` strobe in the ready state raises `drive_k` in the next cycle. `drive_k` stays high until the (RESUME_MS+1)-th tick (default 21), which guarantees at least RESUME_MS ms of K.
- R10: After K ends, `drive_se0` is high for exactly 2*BIT_CYCLES cycles. After that both drives are low. The next tick produces a `sof_marker` and the port is running again.
- R11: Bus activity is flagged only while suspended. A K held on the line while running changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| line_state | input | 2 | Bus line state from the transceiver (SE0=00, J=01, K=10, SE1=11) |
| sof_stop | input | 1 | Strobe: withdraw frame enable (suspend) |
| sof_start | input | 1 | Strobe: re-enable frame generation (ready) |
| resume_req | input | 1 | Strobe: start the downstream resume |
| flag_clr | input | 3 | Write-one-to-clear strobes for the flags |
| flag_q | output | 3 | Sticky flags: [0] wakeup, [1] resume received, [2] resume timeout |
| sof_marker | output | 1 | Start-of-frame marker pulse |
| sof_enabled | output | 1 | Frame generation enabled (not suspended) |
| susp_settled | output | 1 | Device is taken to be asleep |
| drive_k | output | 1 | Drive K on the bus (downstream resume) |
| drive_se0 | output | 1 | Drive SE0 on the bus (end of resume) |

## Verification
The checker assumes that `tick_1ms` is a single-cycle pulse and that each control strobe is high for one cycle. It also assumes that software issues `resume_req` only as a deliberate strobe, so every rise of `drive_k` can be traced to a strobe one cycle earlier. The bench keeps to these assumptions. It drives every strobe and tick for exactly one cycle from the falling edge, spaces ticks at least one idle cycle apart, and never makes a tick coincide with a control strobe. Line-state glitches are applied only in whole clock cycles, so the two-sample filter sees clean steps.

// File: rtl/usbh_susp_pkg.sv
package usbh_susp_pkg;
  typedef enum logic [2:0] {
    HS_RUN      = 3'd0,
    HS_SUSP     = 3'd1,
    HS_READY    = 3'd2,
    HS_RES_K    = 3'd3,
    HS_RES_EOP  = 3'd4,
    HS_WAIT_SOF = 3'd5
  } hs_state_e;

  localparam logic [1:0] LS_SE0 = 2'b00;
  localparam logic [1:0] LS_J   = 2'b01;
  localparam logic [1:0] LS_K   = 2'b10;

  localparam int FLG_WAKE  = 0;
  localparam int FLG_RSM   = 1;
  localparam int FLG_TMO   = 2;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/usbh_line_filter.sv
module usbh_line_filter
  import usbh_susp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_raw,
  output logic [1:0] line_flt,
  output logic       nonj_evt,
  output logic       k_evt
);
  logic [1:0] samp_q;

  // A new value is accepted only when two consecutive samples agree.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q   <= LS_J;
      line_flt <= LS_J;
      nonj_evt <= 1'b0;
      k_evt    <= 1'b0;
    end else begin
      samp_q <= line_raw;
      if (line_raw == samp_q && line_raw != line_flt) begin
        line_flt <= line_raw;
        nonj_evt <= (line_flt == LS_J);
        k_evt    <= (line_raw == LS_K);
      end else begin
        nonj_evt <= 1'b0;
        k_evt    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usbh_sticky_flags.sv
module usbh_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[g] <= 1'b0;
      else if (set_i[g]) q_o[g] <= 1'b1;
      else if (clr_i[g]) q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/usbh_susp_fsm.sv
module usbh_susp_fsm
  import usbh_susp_pkg::*;
#(
  parameter int SETTLE_MS   = 3,
  parameter int RESUME_MS   = 20,
  parameter int DEADLINE_MS = 2,
  parameter int EOP_CYCLES  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sof_stop,
  input  logic sof_start,
  input  logic resume_req,
  input  logic nonj_evt,
  input  logic k_evt,
  output logic sof_marker,
  output logic sof_enabled,
  output logic susp_settled,
  output logic drive_k,
  output logic drive_se0,
  output logic wake_set,
  output logic rsm_set,
  output logic tmo_set
);
  localparam int MS_MAX = (SETTLE_MS > RESUME_MS) ? SETTLE_MS : RESUME_MS;
  localparam int MS_W   = $clog2(MS_MAX + 1);
  localparam int EOP_W  = $clog2(EOP_CYCLES + 1);
  localparam int DL_W   = $clog2(DEADLINE_MS + 1);

  hs_state_e        state, state_nx;
  logic [MS_W-1:0]  ms_cnt;
  logic [EOP_W-1:0] eop_cnt;
  logic [DL_W-1:0]  dl_cnt;
  logic             dl_armed;
  logic             start_k;

  always_comb begin
    state_nx = state;
    unique case (state)
      HS_RUN:      if (sof_stop) state_nx = HS_SUSP;
      HS_SUSP:     if (sof_start) state_nx = HS_READY;
      HS_READY:    if (resume_req) state_nx = HS_RES_K;
                   else if (sof_stop) state_nx = HS_SUSP;
      HS_RES_K:    if (tick && ms_cnt == MS_W'(RESUME_MS)) state_nx = HS_RES_EOP;
      HS_RES_EOP:  if (eop_cnt == EOP_W'(EOP_CYCLES - 1)) state_nx = HS_WAIT_SOF;
      HS_WAIT_SOF: if (tick) state_nx = HS_RUN;
      default:     state_nx = HS_RUN;
    endcase
  end

  assign start_k      = (state == HS_READY) && resume_req;
  assign sof_enabled  = (state != HS_SUSP);
  assign sof_marker   = tick && (state == HS_RUN || state == HS_WAIT_SOF);
  assign susp_settled = (state == HS_SUSP) && (ms_cnt >= MS_W'(SETTLE_MS));
  assign drive_k      = (state == HS_RES_K);
  assign drive_se0    = (state == HS_RES_EOP);
  assign wake_set     = (state == HS_SUSP) && (nonj_evt || k_evt);
  assign rsm_set      = (state == HS_SUSP) && k_evt;
  assign tmo_set      = dl_armed && tick && !start_k &&
                        (dl_cnt == DL_W'(DEADLINE_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= HS_RUN;
      ms_cnt  <= '0;
      eop_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != state)                     ms_cnt <= '0;
      else if (tick && ms_cnt != MS_W'(MS_MAX))  ms_cnt <= ms_cnt + 1'b1;
      if (state == HS_RES_EOP) eop_cnt <= eop_cnt + 1'b1;
      else                     eop_cnt <= '0;
    end
  end

  // Deadline for the host's answer to an upstream resume
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_armed <= 1'b0;
      dl_cnt   <= '0;
    end else if (start_k) begin
      dl_armed <= 1'b0;
    end else if (rsm_set) begin
      dl_armed <= 1'b1;
      dl_cnt   <= '0;
    end else if (dl_armed && tick) begin
      if (dl_cnt == DL_W'(DEADLINE_MS - 1)) dl_armed <= 1'b0;
      else                                  dl_cnt   <= dl_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/usbh_susp_seq.sv
module usbh_susp_seq
  import usbh_susp_pkg::*;
#(
  parameter int SETTLE_MS   = 3,
  parameter int RESUME_MS   = 20,
  parameter int DEADLINE_MS = 2,
  parameter int BIT_CYCLES  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_1ms,
  input  logic [1:0]           line_state,
  input  logic                 sof_stop,
  input  logic                 sof_start,
  input  logic                 resume_req,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic [NUM_FLAGS-1:0] flag_q,
  output logic                 sof_marker,
  output logic                 sof_enabled,
  output logic                 susp_settled,
  output logic                 drive_k,
  output logic                 drive_se0
);
  localparam int EOP_CYCLES = 2 * BIT_CYCLES;

  logic [1:0]           line_flt;
  logic                 nonj_evt, k_evt;
  logic                 wake_set, rsm_set, tmo_set;
  logic [NUM_FLAGS-1:0] flag_set;

  usbh_line_filter i_filt (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_raw (line_state),
    .line_flt (line_flt),
    .nonj_evt (nonj_evt),
    .k_evt    (k_evt)
  );

  usbh_susp_fsm #(
    .SETTLE_MS   (SETTLE_MS),
    .RESUME_MS   (RESUME_MS),
    .DEADLINE_MS (DEADLINE_MS),
    .EOP_CYCLES  (EOP_CYCLES)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_1ms),
    .sof_stop     (sof_stop),
    .sof_start    (sof_start),
    .resume_req   (resume_req),
    .nonj_evt     (nonj_evt),
    .k_evt        (k_evt),
    .sof_marker   (sof_marker),
    .sof_enabled  (sof_enabled),
    .susp_settled (susp_settled),
    .drive_k      (drive_k),
    .drive_se0    (drive_se0),
    .wake_set     (wake_set),
    .rsm_set      (rsm_set),
    .tmo_set      (tmo_set)
  );

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_WAKE] = wake_set;
    flag_set[FLG_RSM]  = rsm_set;
    flag_set[FLG_TMO]  = tmo_set;
  end

  usbh_sticky_flags #(.N(NUM_FLAGS)) i_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (flag_set),
    .clr_i (flag_clr),
    .q_o   (flag_q)
  );

  logic unused_flt;
  assign unused_flt = ^line_flt;
endmodule

// File: rtl/usbh_susp_chk.sv
module usbh_susp_chk #(
  parameter int RESUME_MS = 20,
  parameter int NF        = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_1ms,
  input logic          resume_req,
  input logic          sof_enabled,
  input logic          sof_marker,
  input logic          drive_k,
  input logic          drive_se0,
  input logic          susp_settled,
  input logic [NF-1:0] flag_q,
  input logic [NF-1:0] flag_clr
);
  logic [15:0] k_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               k_ticks <= '0;
    else if (!drive_k)                        k_ticks <= '0;
    else if (tick_1ms && k_ticks != 16'hFFFF) k_ticks <= k_ticks + 1'b1;
  end

  // R2
  marker_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_marker |-> (tick_1ms && sof_enabled && !drive_k && !drive_se0));

  // R3
  settle_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_settled |-> !sof_enabled);

  // R8
  resume_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_req && !sof_enabled) |=> !drive_k);

  // R8
  kdrive_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_k |-> sof_enabled);

  // R9
  k_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_k) |-> $past(resume_req));

  // R9
  k_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_k) |-> (k_ticks >= 16'(RESUME_MS)));

  // R10
  k_se0_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_k && drive_se0));

  for (genvar g = 0; g < NF; g++) begin : g_sticky
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[g] && !flag_clr[g]) |=> flag_q[g]);
  end
endmodule

bind usbh_susp_seq usbh_susp_chk #(.RESUME_MS(RESUME_MS), .NF(3)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_1ms     (tick_1ms),
  .resume_req   (resume_req),
  .sof_enabled  (sof_enabled),
  .sof_marker   (sof_marker),
  .drive_k      (drive_k),
  .drive_se0    (drive_se0),
  .susp_settled (susp_settled),
  .flag_q       (flag_q),
  .flag_clr     (flag_clr)
);

// File: tb/test_usbh_susp_seq.sv
`timescale 1ns/1ps
module test_usbh_susp_seq;
  localparam int RES_MS = 20;
  localparam int BITC   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1ms = 1'b0;
  logic [1:0] line_state = 2'b01;
  logic       sof_stop = 1'b0, sof_start = 1'b0, resume_req = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic [2:0] flag_q;
  logic       sof_marker, sof_enabled, susp_settled, drive_k, drive_se0;

  int checks = 0, errors = 0;
  logic last_marker;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  usbh_susp_seq #(.RESUME_MS(RES_MS), .BIT_CYCLES(BITC)) i_usbh_susp_seq (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .line_state(line_state),
    .sof_stop(sof_stop), .sof_start(sof_start), .resume_req(resume_req),
    .flag_clr(flag_clr), .flag_q(flag_q), .sof_marker(sof_marker),
    .sof_enabled(sof_enabled), .susp_settled(susp_settled),
    .drive_k(drive_k), .drive_se0(drive_se0)
  );

  // fields: line [9:8], hold cycles [7:3], expected flags [2:0]
  localparam logic [9:0] VEC [7] = '{
    {2'b10, 5'd1, 3'b000},
    {2'b00, 5'd1, 3'b000},
    {2'b01, 5'd4, 3'b000},
    {2'b00, 5'd3, 3'b001},
    {2'b10, 5'd2, 3'b011},
    {2'b11, 5'd3, 3'b001},
    {2'b10, 5'd5, 3'b011}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); tick_1ms = 1'b1;
    #1 last_marker = sof_marker;
    @(negedge clk); tick_1ms = 1'b0;
  endtask

  task automatic strobe(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = 3'b000;
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    // R1 reset state
    check("R1 sof_enabled", sof_enabled, 1);
    check("R1 flags", flag_q, 0);
    check("R1 drives", {drive_k, drive_se0}, 0);
    check("R1 settled", susp_settled, 0);
    tick(); check("R1 marker on tick", last_marker, 1);

    // R2 suspend
    strobe(sof_stop);
    check("R2 sof_enabled off", sof_enabled, 0);
    tick(); check("R2 no marker", last_marker, 0);
    // R3 settle after third tick
    tick(); check("R3 settled after 2 ticks", susp_settled, 0);
    tick(); check("R3 settled after 3 ticks", susp_settled, 1);

    // R4 R5 filter and flag table
    for (int i = 0; i < 7; i++) begin
      clear_flags(3'b111);
      @(negedge clk); line_state = VEC[i][9:8];
      cyc(int'(VEC[i][7:3]));
      line_state = 2'b01;
      cyc(4);
      check($sformatf("R4/R5 vector %0d flags", i), flag_q, int'(VEC[i][2:0]));
    end

    // R8 resume while suspended ignored
    strobe(resume_req); cyc(2);
    check("R8 resume ignored drive_k", drive_k, 0);
    check("R8 still suspended", sof_enabled, 0);

    // R7 deadline
    clear_flags(3'b111);
    @(negedge clk); line_state = 2'b10; cyc(3); line_state = 2'b01; cyc(2);
    check("R5 K sets wake and rsm", flag_q, 3'b011);
    tick(); check("R7 no timeout after 1 tick", flag_q[2], 0);
    tick(); check("R7 timeout after 2 ticks", flag_q[2], 1);

    // R6 clear one bit, then set wins over clear
    clear_flags(3'b001);
    check("R6 clear bit0 only", flag_q, 3'b110);
    clear_flags(3'b010);
    check("R6 clear bit1", flag_q, 3'b100);
    @(negedge clk); line_state = 2'b10;
    @(negedge clk);
    @(negedge clk); flag_clr = 3'b011;
    @(negedge clk); flag_clr = 3'b000;
    check("R6 set wins over clear", flag_q, 3'b111);
    line_state = 2'b01; cyc(3);

    // R8 ready state
    strobe(sof_start);
    check("R8 ready sof_enabled", sof_enabled, 1);
    check("R8 ready settled low", susp_settled, 0);
    tick(); check("R8 ready no marker", last_marker, 0);

    // R9 downstream resume
    strobe(resume_req);
    check("R9 drive_k starts", drive_k, 1);
    for (int t = 0; t < RES_MS; t++) tick();
    check("R9 K held through RESUME_MS ticks", drive_k, 1);
    tick();
    check("R9 K ends on next tick", drive_k, 0);
    begin
      int n = 0;
      while (drive_se0 && n < 100) begin n++; @(negedge clk); end
      check("R10 SE0 length", n, 2 * BITC);
    end
    check("R10 idle drives", {drive_k, drive_se0}, 0);
    tick(); check("R10 marker resumes", last_marker, 1);
    tick(); check("R10 running marker", last_marker, 1);

    // R11 activity while running is not flagged
    clear_flags(3'b111);
    @(negedge clk); line_state = 2'b10; cyc(4); line_state = 2'b01; cyc(4);
    check("R11 no flags while running", flag_q, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule